// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Evaluator

This block returns the sine and the cosine of an angle in the first quadrant. It does not use a rotation loop and it does not use a full-range lookup table. The upper bits of the angle select one of 64 evenly spaced breakpoints. A small constant table holds the sine and the cosine of each breakpoint. The lower bits form a short residual angle. The sine and cosine of the residual come from a truncated power series. Four multiplies then combine the two parts through the angle-addition identities:

- sin = s_k·cos r + c_k·sin r
- cos = c_k·cos r − s_k·sin r

The input is a 16-bit unsigned angle `a`, worth a·(π/2)/65536 radians, with a valid flag. The datapath is fully pipelined. It accepts one angle per clock and returns both results, with their own valid flag, a fixed number of cycles later. Quadrant folding belongs to the caller. Every intermediate value keeps its guard bits until one round-to-nearest step in the last stage.

Top module: `quarter_sincos`

## Requirements
- R1: An angle sampled with `in_valid_i` high at rising edge n produces `out_valid_o` high, with its results, after rising edge n+4 (five register stages), for one cycle. Inputs on consecutive cycles give results on consecutive cycles.
- R2: While `rst_ni` is low, `out_valid_o` is low. No result from an angle sampled before reset appears after reset is released.
- R3: Whenever `out_valid_o` is high, `sin_o` and `cos_o` are signed Q1.15 values with bit 15 clear, so they lie in 0..0x7FFF.
- R4: `sin_o` is within 1 LSB of round(32768·sin(a·π/131072)), clamped to 32767.
- R5: `cos_o` is within 1 LSB of round(32768·cos(a·π/131072)), clamped to 32767.
- R6: Angle 0x0000 gives sin 0x0000 and cos 0x7FFF. Angle 0xFFFF gives sin 0x7FFF (saturated) and cos 0x0001.
- R7: Bits 15:10 of the angle select breakpoint k = a[15:10], whose angle is k·(π/2)/64. Bits 9:0 form the residual. Accuracy holds at every breakpoint (a[9:0] = 0) and at the last code before the next breakpoint (a[9:0] = 0x3FF).
- R8: A cycle with `in_valid_i` low yields a cycle with `out_valid_o` low in the matching output slot. Results stay paired with their own inputs across such gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Angle valid |
| angle_i | input | 16 | Unsigned angle, LSB = (π/2)/65536 rad |
| out_valid_o | output | 1 | Results valid |
| sin_o | output | 16 | Sine, signed Q1.15 |
| cos_o | output | 16 | Cosine, signed Q1.15 |

## Verification
Several kinds of internal fault have a distinctive signature at the ports, seen five cycles after the angle that triggers it:

- A wrong constant in the breakpoint table offsets every code in one 1024-code segment.
- A wrong series coefficient or scale grows with the residual, so it is largest at a[9:0] = 0x3FF.
- A misaligned delay between the table path and the series path pairs a result with a neighbouring angle, and random angles show this at once.
- A slip in the valid pipeline appears as an early, late or missing `out_valid_o`, or as one that survives reset.

For these reasons the bench sweeps every code, mixes in random angles with bubbles, and resets the block while its pipeline is full.

// File: rtl/sc_pkg.sv
package sc_pkg;

  // pi in unsigned Q4.60
  localparam logic [63:0] PI_Q60 = 64'h3243F6A8885A308D;
  localparam int unsigned SERIES_TERMS = 12;

  // sin/cos of breakpoint k*(pi/2)/2^idx_w in Q60, by Taylor series (elaboration only)
  function automatic logic [127:0] trig_q60(input int k, input int idx_w, input bit want_cos);
    logic [127:0] th, th2, term, acc;
    th  = (128'(k) * 128'(PI_Q60)) >> (idx_w + 1);
    th2 = (th * th) >> 60;
    if (want_cos) term = 128'(1) << 60;
    else          term = th;
    acc = term;
    for (int n = 1; n <= int'(SERIES_TERMS); n++) begin
      if (want_cos) term = ((term * th2) >> 60) / 128'((2*n-1) * (2*n));
      else          term = ((term * th2) >> 60) / 128'((2*n) * (2*n+1));
      if (n % 2 == 1) acc = acc - term;
      else            acc = acc + term;
    end
    return acc;
  endfunction

  // round Q60 to tb fraction bits
  function automatic logic [63:0] q60_to_frac(input logic [127:0] v, input int tb);
    logic [127:0] r;
    r = (v + (128'(1) << (59 - tb))) >> (60 - tb);
    return r[63:0];
  endfunction

  // residual scale: one angle LSB in Q0.fr radians, rounded
  function automatic logic [63:0] res_scale(input int fr, input int in_w);
    int sh;
    sh = 60 - (fr - in_w - 1);
    return (PI_Q60 + (64'd1 << (sh - 1))) >> sh;
  endfunction

endpackage

// File: rtl/sc_coarse_rom.sv
module sc_coarse_rom #(
  parameter int IDX_W = 6,
  parameter int TB    = 30,
  localparam int TW      = TB + 1,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic [TW-1:0]    sin_o,
  output logic [TW-1:0]    cos_o
);

  logic [TW-1:0] rom_s [ENTRIES];
  logic [TW-1:0] rom_c [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    localparam logic [TW-1:0] SV = TW'(sc_pkg::q60_to_frac(sc_pkg::trig_q60(k, IDX_W, 1'b0), TB));
    localparam logic [TW-1:0] CV = TW'(sc_pkg::q60_to_frac(sc_pkg::trig_q60(k, IDX_W, 1'b1), TB));
    assign rom_s[k] = SV;
    assign rom_c[k] = CV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= rom_s[idx_i];
      cos_o <= rom_c[idx_i];
    end
  end

  // R7: no entry exceeds 1.0
  a_r7_rom_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_o <= (TW'(1) << TB)) && (cos_o <= (TW'(1) << TB)));

endmodule

// File: rtl/sc_residual_series.sv
module sc_residual_series #(
  parameter int IN_W  = 16,
  parameter int RES_W = 10,
  parameter int FR    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] res_i,
  output logic [FR-1:0]    sin_r_o,
  output logic [FR:0]      cos_r_o
);

  localparam int RK_W = FR - IN_W + 2;
  localparam logic [RK_W-1:0] RK  = RK_W'(sc_pkg::res_scale(FR, IN_W));
  localparam logic [FR:0]     ONE = {1'b1, {FR{1'b0}}};
  localparam logic [FR-1:0]   C6  = FR'(((65'd1 << FR) + 65'd3) / 65'd6);

  logic [FR-1:0] r_q1, r_q2, r_q3, r2_q2, r3_q3, sin_r_q4;
  logic [FR:0]   cos_r_q3, cos_r_q4;
  logic [2*FR-1:0] sq_w, cube_w, div_w;

  assign sq_w   = (2*FR)'(r_q1)  * (2*FR)'(r_q1);
  assign cube_w = (2*FR)'(r2_q2) * (2*FR)'(r_q2);
  assign div_w  = (2*FR)'(r3_q3) * (2*FR)'(C6);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q1 <= '0; r_q2 <= '0; r_q3 <= '0;
      r2_q2 <= '0; r3_q3 <= '0;
      cos_r_q3 <= ONE; cos_r_q4 <= ONE;
      sin_r_q4 <= '0;
    end else begin
      // s1: residual angle in radians, Q0.FR
      r_q1     <= FR'(res_i) * FR'(RK);
      // s2: r^2
      r2_q2    <= sq_w[2*FR-1:FR];
      r_q2     <= r_q1;
      // s3: cos r = 1 - r^2/2, r^3
      cos_r_q3 <= ONE - (FR+1)'(r2_q2 >> 1);
      r3_q3    <= cube_w[2*FR-1:FR];
      r_q3     <= r_q2;
      // s4: sin r = r - r^3/6
      sin_r_q4 <= r_q3 - div_w[2*FR-1:FR];
      cos_r_q4 <= cos_r_q3;
    end
  end

  assign sin_r_o = sin_r_q4;
  assign cos_r_o = cos_r_q4;

  // R5: residual cosine stays in (1 - 2^-10, 1]
  a_r5_cos_r_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_r_q3 <= ONE) && (cos_r_q3 > ONE - (ONE >> 10)));
  // R4: residual sine never exceeds the residual it came from
  a_r4_sin_r_le_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sin_r_q4 <= $past(r_q3));

endmodule

// File: rtl/sc_recombine.sv
module sc_recombine #(
  parameter int TB    = 30,
  parameter int FR    = 32,
  parameter int OUT_W = 16,
  localparam int TW = TB + 1,
  localparam int PW = TW + FR + 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TW-1:0]           tab_sin_i,
  input  logic [TW-1:0]           tab_cos_i,
  input  logic [FR-1:0]           sin_r_i,
  input  logic [FR:0]             cos_r_i,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);

  localparam int SH = TB + FR - (OUT_W - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [PW-1:0] HALF = PW'(1) << (SH - 1);

  logic signed [PW-1:0] ts, tc, sr, cr, sum_s, sum_c;

  assign ts = $signed(PW'(tab_sin_i));
  assign tc = $signed(PW'(tab_cos_i));
  assign sr = $signed(PW'(sin_r_i));
  assign cr = $signed(PW'(cos_r_i));

  assign sum_s = ts * cr + tc * sr;
  assign sum_c = tc * cr - ts * sr;

  // single round-to-nearest, then clamp to [0, MAXV]
  function automatic logic [OUT_W-1:0] round_sat(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] q;
    q = (v + HALF) >>> SH;
    if (q < 0)         return '0;
    else if (q > MAXV) return MAXV[OUT_W-1:0];
    else               return q[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= round_sat(sum_s);
      cos_o <= round_sat(sum_c);
    end
  end

endmodule

// File: rtl/quarter_sincos.sv
module quarter_sincos #(
  parameter int IN_W  = 16,
  parameter int IDX_W = 6,
  parameter int FR    = 32,
  parameter int TB    = 30,
  parameter int OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [IN_W-1:0]         angle_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);

  localparam int RES_W = IN_W - IDX_W;
  localparam int TW    = TB + 1;
  localparam int LAT   = 5;
  localparam int DLY   = 3;   // series stages after the table read

  logic [TW-1:0] rom_s, rom_c;
  logic [TW-1:0] ts_pipe [DLY+1];
  logic [TW-1:0] tc_pipe [DLY+1];
  logic [FR-1:0] sin_r;
  logic [FR:0]   cos_r;
  logic [LAT-1:0] vld_q;

  sc_coarse_rom #(.IDX_W(IDX_W), .TB(TB)) i_rom (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_i (angle_i[IN_W-1 -: IDX_W]),
    .sin_o (rom_s),
    .cos_o (rom_c)
  );

  sc_residual_series #(.IN_W(IN_W), .RES_W(RES_W), .FR(FR)) i_series (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .res_i  (angle_i[RES_W-1:0]),
    .sin_r_o(sin_r),
    .cos_r_o(cos_r)
  );

  assign ts_pipe[0] = rom_s;
  assign tc_pipe[0] = rom_c;

  for (genvar g = 0; g < DLY; g++) begin : g_tab_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ts_pipe[g+1] <= '0;
        tc_pipe[g+1] <= '0;
      end else begin
        ts_pipe[g+1] <= ts_pipe[g];
        tc_pipe[g+1] <= tc_pipe[g];
      end
    end
  end

  sc_recombine #(.TB(TB), .FR(FR), .OUT_W(OUT_W)) i_comb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tab_sin_i(ts_pipe[DLY]),
    .tab_cos_i(tc_pipe[DLY]),
    .sin_r_i  (sin_r),
    .cos_r_i  (cos_r),
    .sin_o    (sin_o),
    .cos_o    (cos_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], in_valid_i};
  end

  assign out_valid_o = vld_q[LAT-1];

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##5 out_valid_o);
  a_r8_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##5 !out_valid_o);
  a_r3_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (!sin_o[OUT_W-1] && !cos_o[OUT_W-1]));
  a_r6_zero_angle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && angle_i == '0) |-> ##5 (sin_o == '0 && cos_o == OUT_W'((1 << (OUT_W-1)) - 1)));
  a_r2_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> !out_valid_o);

endmodule

// File: tb/test_quarter_sincos.sv
`timescale 1ns/1ps
module test_quarter_sincos;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] angle = '0;
  logic out_valid_o;
  logic signed [15:0] sin_o, cos_o;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;

  logic        exp_v [5];
  logic [15:0] exp_a [5];

  always #4 clk = ~clk;

  quarter_sincos i_quarter_sincos (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .angle_i    (angle),
    .out_valid_o(out_valid_o),
    .sin_o      (sin_o),
    .cos_o      (cos_o)
  );

  function automatic int ideal(input logic [15:0] a, input bit want_cos);
    real x, y;
    int v;
    x = real'(a) * 3.14159265358979323846 / 131072.0;
    y = want_cos ? $cos(x) : $sin(x);
    v = $rtoi($floor(y * 32768.0 + 0.5));
    if (v > 32767) v = 32767;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference latency model: 5 stages
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin exp_v[i] <= 1'b0; exp_a[i] <= '0; end
    end else begin
      exp_v[0] <= in_valid; exp_a[0] <= angle;
      for (int i = 1; i < 5; i++) begin exp_v[i] <= exp_v[i-1]; exp_a[i] <= exp_a[i-1]; end
    end
  end

  always @(negedge clk) begin
    if (run) begin
      if (!rst_n)
        chk(out_valid_o == 1'b0, "R2 valid in reset", int'(out_valid_o), 0);
      else
        chk(out_valid_o == exp_v[4], exp_v[4] ? "R1 valid" : "R8 bubble",
            int'(out_valid_o), int'(exp_v[4]));
      if (rst_n && exp_v[4] && out_valid_o) begin
        int es, ec, as, ac;
        es = ideal(exp_a[4], 1'b0);
        ec = ideal(exp_a[4], 1'b1);
        as = int'(sin_o);
        ac = int'(cos_o);
        chk(!sin_o[15] && !cos_o[15], "R3 sign", as, es);
        chk(as - es <= 1 && es - as <= 1, "R4 sine", as, es);
        chk(ac - ec <= 1 && ec - ac <= 1, "R5 cosine", ac, ec);
        if (exp_a[4] == 16'h0000) begin
          chk(as == 0, "R6 sin(0)", as, 0);
          chk(ac == 32767, "R6 cos(0)", ac, 32767);
        end
        if (exp_a[4] == 16'hFFFF) begin
          chk(as == 32767, "R6 sin(max)", as, 32767);
          chk(ac == 1, "R6 cos(max)", ac, 1);
        end
        if (exp_a[4][9:0] == 10'h000 || exp_a[4][9:0] == 10'h3FF) begin
          chk(as - es <= 1 && es - as <= 1, "R7 segment edge sine", as, es);
          chk(ac - ec <= 1 && ec - ac <= 1, "R7 segment edge cosine", ac, ec);
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [15:0] a);
    in_valid = v;
    angle = a;
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20161014);
    repeat (3) @(negedge clk);
    // reset state
    chk(out_valid_o == 1'b0, "R2 reset valid", int'(out_valid_o), 0);
    chk(sin_o == 0 && cos_o == 0, "R2 reset data", int'(sin_o), 0);
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    // directed corners
    drive(1'b1, 16'h0000);
    drive(1'b1, 16'hFFFF);
    drive(1'b0, 16'h1234);
    for (int k = 0; k < 64; k++) begin
      drive(1'b1, 16'(k << 10));
      drive(1'b1, 16'((k << 10) | 10'h3FF));
    end
    // full back-to-back sweep
    for (int a = 0; a < 65536; a++) drive(1'b1, 16'(a));
    // random angles with bubbles
    for (int i = 0; i < 20000; i++) drive(($urandom % 4) != 0, 16'($urandom));
    // reset with a full pipeline
    for (int i = 0; i < 3; i++) drive(1'b1, 16'($urandom));
    rst_n = 1'b0;
    drive(1'b0, 16'h0);
    chk(out_valid_o == 1'b0, "R2 reset mid-stream", int'(out_valid_o), 0);
    drive(1'b0, 16'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, 16'h0);
      chk(out_valid_o == 1'b0, "R2 no stale result", int'(out_valid_o), 0);
    end
    drive(1'b1, 16'h0000);
    for (int i = 0; i < 8; i++) drive(1'b0, 16'h0);
    run = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule